// File: doc/BRIEF.md
# Serial Link Port Control Register

This block holds the 32-bit control and status word for one port of a multi-lane serial link, together with the gating that the word applies to the port's packet paths. The read-only upper fields report two widths. The first is the lane count the port was built with, set by a parameter. The second is the width the link reached after training, taken from the training logic through an input. Software can write a width override that forces the link onto a single lane, and can write two control bits: port disable and output enable.

Writes to the control bits have effects on the datapath. While the port is disabled, the receive path is blocked and the drivers send only idles. Both buffer-flush outputs are held high, and writes into the transmit buffer are refused. Clearing the disable bit produces a one-cycle retrain pulse toward the training logic. Clearing output enable stops ordinary packets from being issued, but maintenance packets are still granted.

Top module: `link_port_ctl`

## Requirements
- R1: Bits [31:30] read the built width: 00 for one lane, 10 for two lanes and 01 for four lanes, according to the LANES parameter. Writes do not change them.
- R2: Bits [29:27] always read the current `trained_width` input (000 lane 0 only, 001 redundancy lane only, 010 four lanes, 011 two lanes). Writes do not change them.
- R3: Bits [26:24] hold the override and reset to 000. A write of 000, 010 or 011 is stored. While the stored value is 010, `force_lane0` is high. While it is 011, `force_redund` is high. For any other stored value, both outputs are low.
- R4: A write whose bits [26:24] carry 001 or any code from 100 to 111 leaves the stored override unchanged.
- R5: Bit 23 (disable) resets to 0 and is written from bit 23 of the write data. While it is 1, `drv_idle_only` is high and `rx_valid_out` is low.
- R6: `force_reinit` is high for exactly the one cycle after a write clears bit 23 from 1 to 0. No pulse follows a write that sets bit 23 or leaves it unchanged.
- R7: While bit 23 is 1, `tx_flush` and `rx_flush` are high and `tx_wr_accept` and `tx_pkt_grant` are low. While bit 23 is 0, `tx_wr_accept` follows `tx_wr_valid` and both flush outputs are low.
- R8: Bit 22 (output enable) resets to 1. While the port is enabled, `tx_pkt_grant` follows `tx_pkt_req` when bit 22 is 1. When bit 22 is 0, it follows `tx_pkt_req` only if `tx_pkt_maint` is high.
- R9: Bits [21:0] read as zero whatever is written.
- R10: A read at an address other than CSR_ADDR returns zero, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | AW | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the addressed register |
| trained_width | input | 3 | Width reached by link training |
| tx_wr_valid | input | 1 | Packet write offered to the transmit buffer |
| tx_wr_accept | output | 1 | Transmit buffer write allowed |
| tx_flush | output | 1 | Reset and hold the transmit buffer empty |
| tx_pkt_req | input | 1 | Request to issue a packet on the link |
| tx_pkt_maint | input | 1 | Requested packet is a maintenance packet |
| tx_pkt_grant | output | 1 | Packet issue permitted |
| rx_valid_in | input | 1 | Received packet valid from the link |
| rx_valid_out | output | 1 | Received packet passed onward |
| rx_flush | output | 1 | Hold the receive buffer empty |
| drv_idle_only | output | 1 | Drivers send idles only |
| force_lane0 | output | 1 | Override to single lane on lane 0 |
| force_redund | output | 1 | Override to single lane on redundancy lane |
| force_reinit | output | 1 | One-cycle pulse to silence and retrain the link |

## Verification
A single register write can change the disable bit, the output-enable bit and the override field at once. The retrain pulse and the reopened packet gating then begin in the same cycle. The bench provokes this by writing one word that clears disable, clears output enable and carries a reserved override code. During that write, ordinary and maintenance issue requests and a transmit buffer write are held active. In the cycle after the write edge, the bench checks all of the following: the pulse is present, the buffer write is accepted, an ordinary request is refused, a maintenance request is granted, and the override read back still holds its earlier value.

// File: rtl/link_port_ctl.sv
module link_port_ctl #(
  parameter int LANES = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] CSR_ADDR = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wr,
  input  logic [AW-1:0] csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic [2:0]    trained_width,
  input  logic          tx_wr_valid,
  output logic          tx_wr_accept,
  output logic          tx_flush,
  input  logic          tx_pkt_req,
  input  logic          tx_pkt_maint,
  output logic          tx_pkt_grant,
  input  logic          rx_valid_in,
  output logic          rx_valid_out,
  output logic          rx_flush,
  output logic          drv_idle_only,
  output logic          force_lane0,
  output logic          force_redund,
  output logic          force_reinit
);

  localparam logic [1:0] BUILT = (LANES == 4) ? 2'b01 : (LANES == 2) ? 2'b10 : 2'b00;
  localparam logic [2:0] OVR_NONE = 3'b000;
  localparam logic [2:0] OVR_L0   = 3'b010;
  localparam logic [2:0] OVR_RED  = 3'b011;

  logic [2:0] ovr_q;
  logic       dis_q, oe_q, reinit_q;

  wire        sel    = csr_addr == CSR_ADDR;
  wire        hit    = csr_wr && sel;
  wire [2:0]  ovr_w  = csr_wdata[26:24];
  wire        ovr_ok = (ovr_w == OVR_NONE) || (ovr_w == OVR_L0) || (ovr_w == OVR_RED);
  wire        unused_wbits = ^{csr_wdata[31:27], csr_wdata[21:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q    <= OVR_NONE;
      dis_q    <= 1'b0;
      oe_q     <= 1'b1;
      reinit_q <= 1'b0;
    end else begin
      reinit_q <= hit && dis_q && !csr_wdata[23];
      if (hit) begin
        if (ovr_ok) ovr_q <= ovr_w;
        dis_q <= csr_wdata[23];
        oe_q  <= csr_wdata[22];
      end
    end
  end

  assign csr_rdata     = sel ? {BUILT, trained_width, ovr_q, dis_q, oe_q, 22'd0} : 32'd0;
  assign tx_flush      = dis_q;
  assign rx_flush      = dis_q;
  assign drv_idle_only = dis_q;
  assign tx_wr_accept  = tx_wr_valid && !dis_q;
  assign rx_valid_out  = rx_valid_in && !dis_q;
  assign tx_pkt_grant  = tx_pkt_req && !dis_q && (oe_q || tx_pkt_maint);
  assign force_lane0   = ovr_q == OVR_L0;
  assign force_redund  = ovr_q == OVR_RED;
  assign force_reinit  = reinit_q;

  // R3
  override_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_lane0 && force_redund));

  // R4
  reserved_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ovr_ok) |=> (csr_rdata[26:24] == $past(ovr_q) || !sel));

  // R6
  reinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_reinit |=> !force_reinit);

  // R6
  reinit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_reinit == $fell(dis_q));

  // R7
  disabled_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> (!tx_wr_accept && !tx_pkt_grant && !rx_valid_out));

  // R8
  maint_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pkt_grant && !tx_pkt_maint) |-> oe_q);

endmodule

// File: tb/link_port_ctl_test.sv
`timescale 1ns/1ps
module link_port_ctl_test;
  localparam logic [7:0] CSR = 8'h5C;

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0;
  logic [7:0] csr_addr = CSR;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [2:0] trained_width = 0;
  logic tx_wr_valid = 0, tx_pkt_req = 0, tx_pkt_maint = 0, rx_valid_in = 0;
  logic tx_wr_accept, tx_flush, tx_pkt_grant, rx_valid_out, rx_flush;
  logic drv_idle_only, force_lane0, force_redund, force_reinit;

  int checks = 0, errors = 0;
  logic [2:0] m_ovr = 0;
  logic m_dis = 0, m_oe = 1;

  always #4 clk = ~clk;

  link_port_ctl #(.LANES(4), .AW(8), .CSR_ADDR(CSR)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {2'b01, trained_width, m_ovr, m_dis, m_oe, 22'd0};
  endfunction

  task automatic wr(input logic [31:0] d, input logic [7:0] a);
    logic old_dis;
    old_dis = m_dis;
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_wr = 0; csr_addr = CSR;
    if (a == CSR) begin
      if (d[26:24] == 3'b000 || d[26:24] == 3'b010 || d[26:24] == 3'b011) m_ovr = d[26:24];
      m_dis = d[23];
      m_oe = d[22];
    end
    #1;
    chk("R6 reinit after write", {31'd0, force_reinit}, {31'd0, old_dis && !m_dis});
  endtask

  task automatic check_gates();
    #1;
    chk("R5 idle", {31'd0, drv_idle_only}, {31'd0, m_dis});
    chk("R5 rx", {31'd0, rx_valid_out}, {31'd0, rx_valid_in && !m_dis});
    chk("R7 flush", {30'd0, tx_flush, rx_flush}, {30'd0, m_dis, m_dis});
    chk("R7 txwr", {31'd0, tx_wr_accept}, {31'd0, tx_wr_valid && !m_dis});
    chk("R8 grant", {31'd0, tx_pkt_grant}, {31'd0, tx_pkt_req && !m_dis && (m_oe || tx_pkt_maint)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 R5 R8 reset word", csr_rdata, exp_word());
    chk("R6 reset reinit", {31'd0, force_reinit}, 32'd0);
    chk("R3 reset forces", {30'd0, force_lane0, force_redund}, 32'd0);

    for (int t = 0; t < 8; t++) begin
      trained_width = 3'(t); #1;
      chk("R2 trained width", {29'd0, csr_rdata[29:27]}, 32'(t));
    end
    trained_width = 3'b010;

    wr(32'hFFFF_FFFF, CSR); #1;
    chk("R1 R2 R4 R9 all-ones write", csr_rdata, exp_word());
    check_gates();

    for (int c = 0; c < 8; c++) begin
      wr({5'b0, 3'(c), 1'b0, 1'b1, 22'h3FFFFF}, CSR); #1;
      chk("R3 R4 override", {29'd0, csr_rdata[26:24]}, {29'd0, m_ovr});
      chk("R3 forces", {30'd0, force_lane0, force_redund}, {30'd0, m_ovr == 3'b010, m_ovr == 3'b011});
      chk("R9 low bits", {10'd0, csr_rdata[21:0]}, 32'd0);
      @(negedge clk); #1;
      chk("R6 pulse one cycle", {31'd0, force_reinit}, 32'd0);
    end

    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 2; o++) begin
        wr({5'b0, m_ovr, 1'(d), 1'(o), 22'd0}, CSR);
        for (int s = 0; s < 16; s++) begin
          {tx_wr_valid, tx_pkt_req, tx_pkt_maint, rx_valid_in} = 4'(s);
          check_gates();
        end
      end

    wr({5'b0, m_ovr, 1'b1, 1'b1, 22'd0}, CSR);
    wr({5'b0, m_ovr, 1'b1, 1'b1, 22'd0}, CSR);
    wr({5'b0, m_ovr, 1'b0, 1'b1, 22'd0}, CSR);
    @(negedge clk); #1;
    chk("R6 pulse ended", {31'd0, force_reinit}, 32'd0);

    wr(32'h0380_0000, CSR + 8'd1); #1;
    chk("R10 stray write no effect", csr_rdata, exp_word());
    csr_addr = CSR + 8'd4; #1;
    chk("R10 stray read zero", csr_rdata, 32'd0);
    csr_addr = CSR;

    wr({5'b0, 3'b010, 1'b1, 1'b1, 22'd0}, CSR);
    tx_wr_valid = 1; tx_pkt_req = 1; tx_pkt_maint = 0; rx_valid_in = 1;
    wr({5'b0, 3'b101, 1'b0, 1'b0, 22'd0}, CSR); #1;
    chk("R4 ovr kept during enable", {29'd0, csr_rdata[26:24]}, 32'd2);
    chk("R6 pulse with oe clear", {31'd0, force_reinit}, 32'd1);
    check_gates();
    tx_pkt_maint = 1;
    check_gates();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule